// File: doc/BRIEF.md
# Recoded Floating-Point Comparator

This block compares two floating-point operands held in the recoded form. In that form the exponent carries one extra bit and subnormals are already normalised. The block reports the relation between the operands as one of four mutually exclusive results: less, equal, greater or unordered. It also produces a five-bit exception flag vector. A mode input selects between a quiet comparison and a signaling comparison, and the mode decides whether a quiet NaN operand raises the invalid flag.

The operands are decoded from the top three bits of their exponent field. `111` marks a NaN, `110` an infinity and `000` a zero; every other pattern is a finite nonzero value. A NaN is signaling when the most significant fraction bit is 0 and quiet when that bit is 1. Finite nonzero values are ordered by exponent and then by fraction. This ordering also holds for subnormals, because the recoded exponent of a subnormal lies below that of every normal number. The results are registered once, so they appear on the clock edge after the operands are presented.

Top module: `fp_compare`

## Requirements
- R1: Outside reset, from the second clock edge after reset is released, exactly one of `res_lt`, `res_eq`, `res_gt` and `res_unord` is high.
- R2: While `rst_n` is low at a clock edge, all outputs are zero after that edge.
- R3: `res_unord` is high one cycle after an operand pair in which either operand has exponent top bits `111` (NaN).
- R4: With `sig_mode` = 1 (signaling), the invalid flag (bit 4 of `exc_flags`) is set for any NaN operand.
- R5: With `sig_mode` = 0 (quiet), the invalid flag is set only when a NaN operand has fraction MSB = 0 (signaling NaN). It stays clear for quiet NaNs and ordered pairs.
- R6: `exc_flags` is ordered {invalid, infinite, overflow, underflow, inexact}, and bits 3..0 are always 0.
- R7: Zeros compare equal whatever their signs.
- R8: Finite nonzero values of equal sign are ordered by exponent and then by fraction. When both values are negative, the magnitude order is reversed.
- R9: Ordered operands of opposite sign that are not both zero compare with the negative one less.
- R10: Infinities of equal sign compare equal. A positive infinity is greater than every finite value, and a negative infinity is less than every finite value.
- R11: Subnormals in normalised recoded form order correctly against each other, against zero and against the smallest normal value.
- R12: `sig_mode` has no effect on the four relation outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | EXP_W+SIG_W+1 | First recoded operand |
| in_b | input | EXP_W+SIG_W+1 | Second recoded operand |
| sig_mode | input | 1 | 1 selects a signaling comparison, 0 a quiet comparison |
| res_lt | output | 1 | a is less than b |
| res_eq | output | 1 | a equals b |
| res_gt | output | 1 | a is greater than b |
| res_unord | output | 1 | At least one operand is a NaN |
| exc_flags | output | 5 | {invalid, infinite, overflow, underflow, inexact} |

## Verification
The relation is exercised with several families of operand pairs:
- Positive pairs that differ only in exponent or only in fraction, which separate the exponent compare from the fraction compare.
- The same pairs made negative, which shows the order reversal.
- Mixed-sign pairs including signed zeros, which test the sign rule and the zero exception to it.
- Infinities against each other and against the largest finite value, which check the special classes.
- Subnormals against zero and against the smallest normal value, which confirm that the recoded exponent orders them correctly.

Quiet and signaling NaNs are placed on each operand in turn and compared under both modes. This pins down the invalid flag for each combination of NaN kind and mode, and an ordered pair in signaling mode shows that the mode alone never raises invalid.

// File: rtl/fcmp_pkg.sv
// Shared types for the recoded floating-point comparator.
package fcmp_pkg;

    // Per-operand class bits decoded from a recoded value.
    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
        logic sign;
    } fcmp_class_t;

    // Relation between the two operands.
    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } fcmp_rel_t;

    localparam int FLAG_W   = 5;
    localparam int FLAG_INV = 4;

endpackage

// File: rtl/fcmp_classify.sv
// Decodes one recoded operand into class bits, exponent field and fraction.
// Assumes a valid recoded encoding. Only the top three exponent bits mark
// the special classes.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic [EXP_W+SIG_W:0] operand,
    output fcmp_class_t          cls,
    output logic [EXP_W:0]       exp_f,
    output logic [SIG_W-2:0]     frac_f
);
    localparam int W    = EXP_W + SIG_W + 1;
    localparam int FMSB = SIG_W - 2;

    logic [2:0] top3;

    // Split the operand into its fields.
    always_comb begin
        exp_f  = operand[W-2 -: EXP_W+1];
        frac_f = operand[FMSB:0];
        top3   = operand[W-2 -: 3];
    end

    // Map the top exponent bits and the fraction MSB onto class flags.
    always_comb begin
        cls.sign    = operand[W-1];
        cls.is_nan  = (top3 == 3'b111);
        cls.is_inf  = (top3 == 3'b110);
        cls.is_zero = (top3 == 3'b000);
        cls.is_snan = (top3 == 3'b111) && !operand[FMSB];
    end
endmodule

// File: rtl/fcmp_magnitude.sv
// Compares operand magnitudes, ignoring sign. Zero is the smallest and
// infinity the largest magnitude. Finite nonzero values compare by exponent
// and then by fraction. Results for NaN operands are don't-care.
module fcmp_magnitude #(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic             a_zero,
    input  logic             a_inf,
    input  logic             b_zero,
    input  logic             b_inf,
    input  logic [EXP_W:0]   exp_a,
    input  logic [EXP_W:0]   exp_b,
    input  logic [SIG_W-2:0] frac_a,
    input  logic [SIG_W-2:0] frac_b,
    output logic             mag_lt,
    output logic             mag_eq
);
    logic exp_lt, exp_eq, frac_lt, frac_eq;

    // Field comparators for the finite path.
    always_comb begin
        exp_lt  = exp_a < exp_b;
        exp_eq  = exp_a == exp_b;
        frac_lt = frac_a < frac_b;
        frac_eq = frac_a == frac_b;
    end

    // Priority chain over the special classes, then the finite compare.
    always_comb begin
        if (a_zero && b_zero) begin
            mag_lt = 1'b0; mag_eq = 1'b1;
        end else if (a_zero) begin
            mag_lt = 1'b1; mag_eq = 1'b0;
        end else if (b_zero) begin
            mag_lt = 1'b0; mag_eq = 1'b0;
        end else if (a_inf && b_inf) begin
            mag_lt = 1'b0; mag_eq = 1'b1;
        end else if (a_inf) begin
            mag_lt = 1'b0; mag_eq = 1'b0;
        end else if (b_inf) begin
            mag_lt = 1'b1; mag_eq = 1'b0;
        end else begin
            mag_lt = exp_lt || (exp_eq && frac_lt);
            mag_eq = exp_eq && frac_eq;
        end
    end
endmodule

// File: rtl/fcmp_resolve.sv
// Combines the class bits and the magnitude order into a four-way relation
// and the invalid flag. Signs apply after the magnitude compare.
module fcmp_resolve
    import fcmp_pkg::*;
(
    input  logic      a_nan,
    input  logic      a_snan,
    input  logic      a_zero,
    input  logic      a_sign,
    input  logic      b_nan,
    input  logic      b_snan,
    input  logic      b_zero,
    input  logic      b_sign,
    input  logic      mag_lt,
    input  logic      mag_eq,
    input  logic      sig_mode,
    output fcmp_rel_t rel,
    output logic      invalid
);
    // Choose the relation: unordered first, then zeros, then signs.
    always_comb begin
        if (a_nan || b_nan)
            rel = REL_UN;
        else if (a_zero && b_zero)
            rel = REL_EQ;
        else if (a_sign != b_sign)
            rel = a_sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (mag_lt ^ a_sign)
            rel = REL_LT;
        else
            rel = REL_GT;
    end

    // Invalid: any NaN in signaling mode, signaling NaNs only in quiet mode.
    always_comb begin
        if (sig_mode)
            invalid = a_nan || b_nan;
        else
            invalid = a_snan || b_snan;
    end
endmodule

// File: rtl/fp_compare.sv
// Top of the recoded floating-point comparator. Decodes both operands,
// compares them and registers the four-way relation and the flag vector.
// Latency is one clock. Reset is synchronous and active low.
module fp_compare
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [EXP_W+SIG_W:0]   in_a,
    input  logic [EXP_W+SIG_W:0]   in_b,
    input  logic                   sig_mode,
    output logic                   res_lt,
    output logic                   res_eq,
    output logic                   res_gt,
    output logic                   res_unord,
    output logic [FLAG_W-1:0]      exc_flags
);
    localparam int W     = EXP_W + SIG_W + 1;
    localparam int N_OPS = 2;

    logic [W-1:0]     ops  [N_OPS];
    fcmp_class_t      cls  [N_OPS];
    logic [EXP_W:0]   expf [N_OPS];
    logic [SIG_W-2:0] frac [N_OPS];

    logic      mag_lt, mag_eq, invalid;
    fcmp_rel_t rel;

    // Gather the operands into an array for the decoder loop.
    always_comb begin
        ops[0] = in_a;
        ops[1] = in_b;
    end

    for (genvar i = 0; i < N_OPS; i++) begin : g_dec
        fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .operand (ops[i]),
            .cls     (cls[i]),
            .exp_f   (expf[i]),
            .frac_f  (frac[i])
        );
    end

    fcmp_magnitude #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_mag (
        .a_zero (cls[0].is_zero),
        .a_inf  (cls[0].is_inf),
        .b_zero (cls[1].is_zero),
        .b_inf  (cls[1].is_inf),
        .exp_a  (expf[0]),
        .exp_b  (expf[1]),
        .frac_a (frac[0]),
        .frac_b (frac[1]),
        .mag_lt (mag_lt),
        .mag_eq (mag_eq)
    );

    fcmp_resolve u_res (
        .a_nan    (cls[0].is_nan),
        .a_snan   (cls[0].is_snan),
        .a_zero   (cls[0].is_zero),
        .a_sign   (cls[0].sign),
        .b_nan    (cls[1].is_nan),
        .b_snan   (cls[1].is_snan),
        .b_zero   (cls[1].is_zero),
        .b_sign   (cls[1].sign),
        .mag_lt   (mag_lt),
        .mag_eq   (mag_eq),
        .sig_mode (sig_mode),
        .rel      (rel),
        .invalid  (invalid)
    );

    // Output register: one-hot relation and flag vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lt    <= 1'b0;
            res_eq    <= 1'b0;
            res_gt    <= 1'b0;
            res_unord <= 1'b0;
            exc_flags <= '0;
        end else begin
            res_lt    <= (rel == REL_LT);
            res_eq    <= (rel == REL_EQ);
            res_gt    <= (rel == REL_GT);
            res_unord <= (rel == REL_UN);
            exc_flags <= {invalid, {(FLAG_W-1){1'b0}}};
        end
    end
endmodule

// File: rtl/fcmp_checker.sv
// Property checker for fp_compare. It relates the registered outputs to the
// operands of the previous cycle and is attached with a bind.
module fcmp_checker #(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [EXP_W+SIG_W:0] in_a,
    input logic [EXP_W+SIG_W:0] in_b,
    input logic                 sig_mode,
    input logic                 res_lt,
    input logic                 res_eq,
    input logic                 res_gt,
    input logic                 res_unord,
    input logic [4:0]           exc_flags
);
    localparam int W = EXP_W + SIG_W + 1;

    logic a_nan, b_nan, a_zero, b_zero;

    // Independent class decode for the properties.
    always_comb begin
        a_nan  = in_a[W-2 -: 3] == 3'b111;
        b_nan  = in_b[W-2 -: 3] == 3'b111;
        a_zero = in_a[W-2 -: 3] == 3'b000;
        b_zero = in_b[W-2 -: 3] == 3'b000;
    end

    assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot({res_lt, res_eq, res_gt, res_unord}));

    assert_unord_on_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_unord == ($past(a_nan) || $past(b_nan))));

    assert_sig_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sig_mode)) |-> (exc_flags[4] == res_unord));

    assert_quiet_ordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !res_unord) |-> !exc_flags[4]);

    assert_no_other_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flags[3:0] == 4'b0000);

    assert_zeros_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_zero) && $past(b_zero)) |-> res_eq);

    assert_self_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_a == in_b) && !res_unord) |-> res_eq);
endmodule

bind fp_compare fcmp_checker #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_fcmp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_a      (in_a),
    .in_b      (in_b),
    .sig_mode  (sig_mode),
    .res_lt    (res_lt),
    .res_eq    (res_eq),
    .res_gt    (res_gt),
    .res_unord (res_unord),
    .exc_flags (exc_flags)
);

// File: tb/fp_compare_tb.sv
// Directed bench for fp_compare with the default 8/24 format (33-bit operands).
module fp_compare_tb;
    localparam int EW = 8;
    localparam int SW = 24;
    localparam int W  = EW + SW + 1;

    // Expected relation codes (one-hot {lt,eq,gt,un}).
    localparam logic [3:0] LT = 4'b1000;
    localparam logic [3:0] EQ = 4'b0100;
    localparam logic [3:0] GT = 4'b0010;
    localparam logic [3:0] UN = 4'b0001;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         sig_mode = 1'b0;
    logic         res_lt, res_eq, res_gt, res_unord;
    logic [4:0]   exc_flags;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    fp_compare #(.EXP_W(EW), .SIG_W(SW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_a      (in_a),
        .in_b      (in_b),
        .sig_mode  (sig_mode),
        .res_lt    (res_lt),
        .res_eq    (res_eq),
        .res_gt    (res_gt),
        .res_unord (res_unord),
        .exc_flags (exc_flags)
    );

    // Build a recoded value from sign, 9-bit exponent field and 23-bit fraction.
    function automatic logic [W-1:0] fp(input logic s, input logic [8:0] e, input logic [22:0] f);
        return {s, e, f};
    endfunction

    // Recoded constants: exponent 0x100 is 1.0, 0x180 infinity, 0x1C0 NaN.
    localparam logic [8:0] E_ONE = 9'h100;
    localparam logic [8:0] E_INF = 9'h180;
    localparam logic [8:0] E_NAN = 9'h1C0;

    // Apply one pair and check the relation and the flags one clock later.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic mode,
                         input logic [3:0] exp_rel, input logic exp_inv, input string tag);
        logic [3:0] got;
        @(negedge clk);
        in_a = a; in_b = b; sig_mode = mode;
        @(negedge clk);
        got = {res_lt, res_eq, res_gt, res_unord};
        n_vec++;
        if (got !== exp_rel || exc_flags !== {exp_inv, 4'b0000}) begin
            n_fail++;
            $display("FAIL %s: rel=%b flags=%b expected rel=%b flags=%b",
                     tag, got, exc_flags, exp_rel, {exp_inv, 4'b0000});
        end
    endtask

    task automatic t_reset();
        // R2: outputs held at zero during reset even with live operands.
        @(negedge clk);
        rst_n = 1'b0; in_a = fp(0, E_ONE, 0); in_b = fp(0, E_NAN, 0); sig_mode = 1'b1;
        repeat (2) @(negedge clk);
        n_vec++;
        if ({res_lt, res_eq, res_gt, res_unord, exc_flags} !== 9'b0) begin
            n_fail++;
            $display("FAIL R2: outputs=%b expected=%b",
                     {res_lt, res_eq, res_gt, res_unord, exc_flags}, 9'b0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_same_sign();
        apply(fp(0, E_ONE, 0), fp(0, E_ONE + 1, 0), 0, LT, 0, "R8 pos exp lt");
        apply(fp(0, E_ONE, 23'h400000), fp(0, E_ONE, 23'h200000), 0, GT, 0, "R8 pos frac gt");
        apply(fp(0, E_ONE + 1, 23'h000001), fp(0, E_ONE + 1, 23'h000001), 0, EQ, 0, "R8 equal");
        apply(fp(1, E_ONE, 0), fp(1, E_ONE + 1, 0), 0, GT, 0, "R8 neg exp reversed");
        apply(fp(1, E_ONE, 23'h000002), fp(1, E_ONE, 23'h000001), 0, LT, 0, "R8 neg frac reversed");
    endtask

    task automatic t_zeros_and_signs();
        apply(fp(0, 0, 0), fp(1, 0, 0), 0, EQ, 0, "R7 +0 vs -0");
        apply(fp(1, 0, 0), fp(0, 0, 0), 0, EQ, 0, "R7 -0 vs +0");
        apply(fp(1, E_ONE, 0), fp(0, 0, 0), 0, LT, 0, "R9 -1 vs +0");
        apply(fp(0, 0, 0), fp(1, E_ONE, 0), 0, GT, 0, "R9 +0 vs -1");
        apply(fp(1, 9'h080, 0), fp(0, 9'h080, 0), 0, LT, 0, "R9 -tiny vs +tiny");
    endtask

    task automatic t_infinities();
        apply(fp(0, E_INF, 0), fp(0, E_INF, 0), 0, EQ, 0, "R10 +inf eq");
        apply(fp(1, E_INF, 0), fp(1, E_INF, 0), 0, EQ, 0, "R10 -inf eq");
        apply(fp(0, E_INF, 0), fp(0, 9'h17F, 23'h7FFFFF), 0, GT, 0, "R10 +inf vs max");
        apply(fp(1, E_INF, 0), fp(1, 9'h17F, 23'h7FFFFF), 0, LT, 0, "R10 -inf vs -max");
        apply(fp(1, E_INF, 0), fp(0, E_INF, 0), 0, LT, 0, "R10 -inf vs +inf");
    endtask

    task automatic t_subnormals();
        // Smallest normal has exponent field 0x082; subnormals sit below it.
        apply(fp(0, 0, 0), fp(0, 9'h06B, 0), 0, LT, 0, "R11 zero vs min subnormal");
        apply(fp(0, 9'h07F, 23'h7FFFFF), fp(0, 9'h080, 0), 0, LT, 0, "R11 sub vs sub");
        apply(fp(0, 9'h081, 23'h7FFFFF), fp(0, 9'h082, 0), 0, LT, 0, "R11 sub vs min normal");
        apply(fp(1, 9'h081, 0), fp(1, 9'h082, 0), 0, GT, 0, "R11 neg sub vs neg normal");
    endtask

    task automatic t_nans();
        logic [W-1:0] qnan, snan;
        qnan = fp(0, E_NAN, 23'h400000);
        snan = fp(1, E_NAN, 23'h000001);
        apply(qnan, fp(0, E_ONE, 0), 0, UN, 0, "R3 R5 qnan a quiet");
        apply(fp(0, E_ONE, 0), qnan, 0, UN, 0, "R3 R5 qnan b quiet");
        apply(qnan, fp(0, E_ONE, 0), 1, UN, 1, "R4 qnan a signaling");
        apply(fp(0, 0, 0), qnan, 1, UN, 1, "R4 qnan b signaling");
        apply(snan, fp(0, E_ONE, 0), 0, UN, 1, "R5 snan a quiet");
        apply(fp(0, E_INF, 0), snan, 0, UN, 1, "R5 snan b quiet");
        apply(qnan, qnan, 0, UN, 0, "R3 R5 both qnan quiet");
        apply(snan, snan, 1, UN, 1, "R4 both snan signaling");
    endtask

    task automatic t_mode();
        apply(fp(0, E_ONE, 0), fp(0, E_ONE + 1, 0), 1, LT, 0, "R12 R6 signaling ordered lt");
        apply(fp(0, E_INF, 0), fp(0, E_INF, 0), 1, EQ, 0, "R12 signaling inf eq");
        apply(fp(1, E_ONE, 0), fp(0, 0, 0), 1, LT, 0, "R12 signaling mixed sign");
    endtask

    task automatic t_one_hot();
        // R1: back-to-back vectors, each result must be one-hot.
        apply(fp(0, E_ONE, 0), fp(0, E_ONE, 0), 0, EQ, 0, "R1 eq");
        apply(fp(0, E_ONE + 2, 0), fp(0, E_ONE, 0), 0, GT, 0, "R1 gt");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_one_hot();
        t_same_sign();
        t_zeros_and_signs();
        t_infinities();
        t_subnormals();
        t_nans();
        t_mode();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion before", 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule